// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host reach the on-chip packet memory of a network controller one access at a time through a single data port. The register block loads a remote start address and a remote byte count. After that, each strobe on the port reads or writes 1, 2 or 4 bytes, least significant byte first. After every access the address steps forward by the access size and the byte count steps down by the same amount. When the address hits the ring stop boundary, it reloads from the ring start boundary. When the count runs out, a one-cycle completion pulse is raised.

Two regions are reachable. The first is a 32-byte station-address PROM. It is preset at reset and can be overwritten. The second is a packet RAM from `PMEM_START` up to `MEM_SIZE`. Any other address is outside the window: a read there returns all ones and a write there is dropped. Once the byte count has reached zero, data-port writes are ignored.

Top module: `rdma_port`

## Requirements
- R1: After reset, addr_o, cnt_o, done_o and rvalid_o are 0. PROM byte k (0 to 5) holds STATION[8k+7:8k]. PROM bytes 14 and 15 hold 0x57. Every other PROM byte from 6 to 31 holds 0xFF.
- R2: When ld_i is high, addr_o takes ld_addr_i and cnt_o takes ld_cnt_i on the next cycle. A port strobe in the same cycle is ignored: no read is returned and no write is made.
- R3: size_i selects the access size: 00 is 1 byte, 01 is 2 bytes, 10 and 11 are 4 bytes. 2-byte and 4-byte accesses clear bit 0 of the address before using it.
- R4: Data is little-endian. The byte at the lowest address travels on bits [7:0] of wdata_i and rdata_o. rdata_o bits above the access width read as 0.
- R5: A byte is in the window if its offset is 0 to 31, or PMEM_START to MEM_SIZE-1. If the (even-forced) start address is outside the window, a read returns 0xFF in every byte of the access width and a write changes nothing. Within an access that starts inside the window, any byte that falls outside the window reads as 0xFF and is not written.
- R6: rdata_o is valid, with rvalid_o high, for exactly the one cycle after a read strobe. rvalid_o stays low after a write strobe or a load.
- R7: After each read, and after each write made with a nonzero count, addr_o becomes the old address (before forcing even) plus the size, modulo 2^16. If that sum equals page_stop_i<<8, addr_o becomes page_start_i<<8 instead.
- R8: On each such access, if cnt_o is less than or equal to the size, cnt_o becomes 0 and done_o pulses high for one cycle. Otherwise cnt_o drops by the size and done_o stays low. A read made with a zero count still advances the address and pulses done_o.
- R9: A write strobe made while cnt_o is 0 leaves memory, addr_o and cnt_o unchanged and does not pulse done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_i | input | 1 | Load address and count |
| ld_addr_i | input | 16 | Remote start address to load |
| ld_cnt_i | input | 16 | Remote byte count to load |
| page_start_i | input | 8 | Ring start page |
| page_stop_i | input | 8 | Ring stop page |
| acc_i | input | 1 | Data port strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size code |
| wdata_i | input | 32 | Write data, little-endian |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data, little-endian |
| addr_o | output | 16 | Current remote address |
| cnt_o | output | 16 | Remaining byte count |
| done_o | output | 1 | Completion pulse |

## Verification
Every result of a strobe or a load at one rising edge is due at the next edge: read data, rvalid_o, the new address, the new count and the done pulse. The bench drives inputs on the falling edge. At the following falling edge it compares all outputs against a byte-array model of the memory, the address and the count. Reads right after writes confirm that the write landed, or for dropped and zero-count writes, that nothing changed.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int unsigned PROM_BYTES = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } acc_size_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic in_win(input logic [15:0] a, input int unsigned lo,
                                  input int unsigned hi);
    logic [31:0] w;
    w = {16'h0000, a};
    return (w < PROM_BYTES) || ((w >= lo) && (w < hi));
  endfunction
endpackage

// File: rtl/rdma_window.sv
module rdma_window
  import rdma_pkg::*;
#(
  parameter int unsigned MEM_SIZE   = 2048,
  parameter int unsigned PMEM_START = 1024
) (
  input  logic             act_i,
  input  logic [15:0]      base_i,
  input  logic [2:0]       nb_i,
  output logic             start_ok_o,
  output logic [3:0]       en_o,
  output logic [3:0]       prom_o,
  output logic [3:0][15:0] baddr_o
);
  assign start_ok_o = in_win(base_i, PMEM_START, MEM_SIZE);

  for (genvar i = 0; i < 4; i++) begin : g_byte
    assign baddr_o[i] = base_i + 16'(i);
    assign en_o[i]    = act_i && (3'(i) < nb_i) && start_ok_o &&
                        in_win(baddr_o[i], PMEM_START, MEM_SIZE);
    assign prom_o[i]  = baddr_o[i] < 16'(PROM_BYTES);
  end
endmodule

// File: rtl/rdma_lane_ram.sv
module rdma_lane_ram #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/rdma_prom.sv
module rdma_prom
  import rdma_pkg::*;
#(
  parameter logic [47:0] STATION = 48'h66_55_44_33_22_02
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [3:0]      we_i,
  input  logic [3:0][4:0] addr_i,
  input  logic [3:0][7:0] wdata_i,
  output logic [3:0][7:0] rdata_o
);
  logic [7:0] rom_q [PROM_BYTES];

  function automatic logic [7:0] init_byte(input int k);
    if (k < 6) return STATION[8*k +: 8];
    if (k == 14 || k == 15) return 8'h57;
    return 8'hff;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < PROM_BYTES; k++) rom_q[k] <= init_byte(k);
    end else begin
      for (int i = 0; i < 4; i++)
        if (we_i[i]) rom_q[addr_i[i]] <= wdata_i[i];
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_rd
    assign rdata_o[i] = rom_q[addr_i[i]];
  end
endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int unsigned MEM_SIZE   = 2048,
  parameter int unsigned PMEM_START = 1024,
  parameter logic [47:0] STATION    = 48'h66_55_44_33_22_02
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ld_i,
  input  logic [15:0] ld_addr_i,
  input  logic [15:0] ld_cnt_i,
  input  logic [7:0]  page_start_i,
  input  logic [7:0]  page_stop_i,
  input  logic        acc_i,
  input  logic        wr_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  output logic        rvalid_o,
  output logic [31:0] rdata_o,
  output logic [15:0] addr_o,
  output logic [15:0] cnt_o,
  output logic        done_o
);
  localparam int unsigned RAM_DEPTH = (MEM_SIZE - PMEM_START) / 4;
  localparam int unsigned RAM_AW    = $clog2(RAM_DEPTH);

  logic [15:0] addr_q, cnt_q;
  logic        done_q, rv_q;

  logic        go, wr_go, rd_go, upd;
  logic [2:0]  nb;
  logic [15:0] a_even, addr_sum;
  logic        start_ok;
  logic [3:0]  ben, bprom;
  logic [3:0][15:0] baddr;
  logic [3:0][7:0]  prom_rd, prom_wd;
  logic [3:0][4:0]  prom_ad;
  logic [3:0][7:0]  lane_rd;

  logic [1:0]       rsh_q;
  logic [3:0]       ren_q, rprom_q, rmask_q;
  logic [3:0][7:0]  rpdat_q;

  assign go     = acc_i && !ld_i;
  assign nb     = size_bytes(size_i);
  assign a_even = (nb == 3'd1) ? addr_q : {addr_q[15:1], 1'b0};
  assign wr_go  = go && wr_i && (cnt_q != 16'd0);
  assign rd_go  = go && !wr_i;
  assign upd    = wr_go || rd_go;

  rdma_window #(.MEM_SIZE(MEM_SIZE), .PMEM_START(PMEM_START)) i_window (
    .act_i     (go),
    .base_i    (a_even),
    .nb_i      (nb),
    .start_ok_o(start_ok),
    .en_o      (ben),
    .prom_o    (bprom),
    .baddr_o   (baddr)
  );

  for (genvar i = 0; i < 4; i++) begin : g_pmap
    assign prom_ad[i] = baddr[i][4:0];
    assign prom_wd[i] = wdata_i[8*i +: 8];
  end

  rdma_prom #(.STATION(STATION)) i_prom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   ({4{wr_go}} & ben & bprom),
    .addr_i (prom_ad),
    .wdata_i(prom_wd),
    .rdata_o(prom_rd)
  );

  // lane L holds bytes whose address mod 4 equals L
  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [1:0]  sel;
    logic [15:0] roff;
    logic        hit;
    assign sel  = 2'(l) - a_even[1:0];
    assign roff = baddr[sel] - 16'(PMEM_START);
    assign hit  = ben[sel] && !bprom[sel];

    rdma_lane_ram #(.DEPTH(RAM_DEPTH)) i_ram (
      .clk_i  (clk_i),
      .we_i   (wr_go && hit),
      .re_i   (rd_go && hit),
      .addr_i (roff[RAM_AW+1:2]),
      .wdata_i(wdata_i[{sel, 3'b000} +: 8]),
      .rdata_o(lane_rd[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q    <= 1'b0;
      rsh_q   <= '0;
      ren_q   <= '0;
      rprom_q <= '0;
      rmask_q <= '0;
      rpdat_q <= '0;
    end else begin
      rv_q <= rd_go;
      if (rd_go) begin
        rsh_q   <= a_even[1:0];
        ren_q   <= ben;
        rprom_q <= bprom;
        rpdat_q <= prom_rd;
        rmask_q <= {nb[2], nb[2], nb[2] | nb[1], 1'b1};
      end
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_rmux
    logic [1:0] lidx;
    assign lidx = rsh_q + 2'(i);
    assign rdata_o[8*i +: 8] = !rmask_q[i] ? 8'h00 :
                               !ren_q[i]   ? 8'hff :
                               rprom_q[i]  ? rpdat_q[i] : lane_rd[lidx];
  end

  assign addr_sum = addr_q + 16'(nb);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (ld_i) begin
      addr_q <= ld_addr_i;
      cnt_q  <= ld_cnt_i;
      done_q <= 1'b0;
    end else if (upd) begin
      addr_q <= (addr_sum == {page_stop_i, 8'h00}) ? {page_start_i, 8'h00} : addr_sum;
      if (cnt_q <= 16'(nb)) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - 16'(nb);
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign rvalid_o = rv_q;
  assign addr_o   = addr_q;
  assign cnt_o    = cnt_q;
  assign done_o   = done_q;

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (addr_o == $past(ld_addr_i)) && (cnt_o == $past(ld_cnt_i)) && !rvalid_o); // R2
  AST_OOW_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !wr_i && !ld_i && !start_ok) |=> (rdata_o[7:0] == 8'hff)); // R5
  AST_RVALID_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !wr_i && !ld_i) |=> rvalid_o); // R6
  AST_RVALID_ONLY_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_i && !wr_i && !ld_i) |=> !rvalid_o); // R6
  AST_CNT_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !ld_i) |=> (cnt_o <= $past(cnt_o))); // R8
  AST_DONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cnt_o == 16'd0)); // R8
  AST_ZERO_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && wr_i && !ld_i && (cnt_o == 16'd0)) |=>
      ($stable(addr_o) && $stable(cnt_o) && !done_o)); // R9
endmodule

// File: tb/test_rdma_port.sv
`timescale 1ns/1ps
module test_rdma_port;
  localparam int MEM_SIZE   = 2048;
  localparam int PMEM_START = 1024;
  localparam logic [47:0] STATION = 48'h66_55_44_33_22_02;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_i = 1'b0;
  logic [15:0] ld_addr_i = '0, ld_cnt_i = '0;
  logic [7:0]  page_start_i = 8'h04, page_stop_i = 8'h08;
  logic        acc_i = 1'b0, wr_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic        rvalid_o, done_o;
  logic [31:0] rdata_o;
  logic [15:0] addr_o, cnt_o;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [7:0] mem_m [MEM_SIZE];
  int addr_m, cnt_m;

  always #5 clk = ~clk;

  rdma_port #(.MEM_SIZE(MEM_SIZE), .PMEM_START(PMEM_START), .STATION(STATION)) i_rdma_port (
    .clk_i(clk), .rst_ni(rst_ni), .ld_i(ld_i), .ld_addr_i(ld_addr_i), .ld_cnt_i(ld_cnt_i),
    .page_start_i(page_start_i), .page_stop_i(page_stop_i), .acc_i(acc_i), .wr_i(wr_i),
    .size_i(size_i), .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
    .addr_o(addr_o), .cnt_o(cnt_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit win(input int b);
    return (b >= 0 && b < 32) || (b >= PMEM_START && b < MEM_SIZE);
  endfunction

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  // called just after a falling edge; returns just after the next one
  task automatic load(input int a, input int c);
    ld_i = 1'b1; ld_addr_i = 16'(a); ld_cnt_i = 16'(c);
    acc_i = 1'b1; wr_i = 1'b0; size_i = 2'b10;
    @(negedge clk);
    ld_i = 1'b0; acc_i = 1'b0;
    addr_m = a & 16'hffff; cnt_m = c & 16'hffff;
    chk(addr_o === 16'(addr_m), "R2 addr", 32'(addr_o), 32'(addr_m));
    chk(cnt_o === 16'(cnt_m), "R2 cnt", 32'(cnt_o), 32'(cnt_m));
    chk(rvalid_o === 1'b0, "R2 strobe ignored", 32'(rvalid_o), 32'd0);
  endtask

  task automatic access(input bit wr, input logic [1:0] sz, input logic [31:0] wd, input string tag);
    int n, a, b;
    bit sok, upd, exp_done;
    logic [31:0] exp;
    n = nbytes(sz);
    a = (n == 1) ? addr_m : (addr_m & 32'hfffe);
    sok = win(a);
    exp = '0;
    for (int i = 0; i < n; i++) begin
      b = a + i;
      exp[8*i +: 8] = (sok && win(b)) ? mem_m[b] : 8'hff;
    end
    if (wr && cnt_m != 0)
      for (int i = 0; i < n; i++) begin
        b = a + i;
        if (sok && win(b)) mem_m[b] = wd[8*i +: 8];
      end
    upd = !wr || (cnt_m != 0);
    exp_done = 1'b0;
    if (upd) begin
      addr_m = (addr_m + n) & 32'hffff;
      if (addr_m == (int'(page_stop_i) << 8)) addr_m = int'(page_start_i) << 8;
      if (cnt_m <= n) begin cnt_m = 0; exp_done = 1'b1; end
      else cnt_m -= n;
    end
    acc_i = 1'b1; wr_i = wr; size_i = sz; wdata_i = wd;
    @(negedge clk);
    acc_i = 1'b0;
    if (!wr) begin
      chk(rvalid_o === 1'b1, "R6 rvalid", 32'(rvalid_o), 32'd1);
      chk(rdata_o === exp, tag, rdata_o, exp);
    end else begin
      chk(rvalid_o === 1'b0, "R6 no rvalid on write", 32'(rvalid_o), 32'd0);
    end
    chk(addr_o === 16'(addr_m), (wr && !upd) ? "R9 addr" : "R7 addr", 32'(addr_o), 32'(addr_m));
    chk(cnt_o === 16'(cnt_m), (wr && !upd) ? "R9 cnt" : "R8 cnt", 32'(cnt_o), 32'(cnt_m));
    chk(done_o === exp_done, (wr && !upd) ? "R9 done" : "R8 done", 32'(done_o), 32'(exp_done));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    for (int k = 0; k < MEM_SIZE; k++) mem_m[k] = 8'hxx;
    for (int k = 0; k < 32; k++)
      mem_m[k] = (k < 6) ? STATION[8*k +: 8] : (k == 14 || k == 15) ? 8'h57 : 8'hff;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset outputs
    chk(addr_o === 16'h0 && cnt_o === 16'h0, "R1 counters", {addr_o, cnt_o}, 32'h0);
    chk(done_o === 1'b0 && rvalid_o === 1'b0, "R1 flags", {30'h0, done_o, rvalid_o}, 32'h0);

    // R1 PROM contents, R4 byte order
    load(0, 100);
    for (int k = 0; k < 8; k++) access(1'b0, 2'b10, '0, "R1 R4 prom word");

    // fill packet RAM; final access ends the count and wraps (R7, R8)
    load(PMEM_START, MEM_SIZE - PMEM_START);
    for (int k = 0; k < (MEM_SIZE - PMEM_START) / 4; k++)
      access(1'b1, 2'b10, $urandom(), "R4 fill");
    chk(addr_o === 16'(PMEM_START), "R7 wrap after fill", 32'(addr_o), PMEM_START);

    // R9 write at zero count, then read shows unchanged memory
    access(1'b1, 2'b10, 32'hdeadbeef, "R9 write");
    load(PMEM_START, 0);
    access(1'b0, 2'b10, '0, "R9 read back (R8 zero-count read)");

    // R7 wrap on 2-byte read at stop-2
    load(16'h07fe, 10);
    access(1'b0, 2'b01, '0, "R7 read at ring end");
    chk(addr_o === 16'h0400, "R7 wrapped", 32'(addr_o), 32'h400);

    // R3 odd address forced even for 2 bytes, kept for 1 byte
    load(16'h0403, 20);
    access(1'b0, 2'b01, '0, "R3 half odd");
    access(1'b0, 2'b00, '0, "R3 byte odd");
    access(1'b0, 2'b11, '0, "R3 size 11 as word");

    // R5 outside window at each width
    load(16'h0100, 20);
    access(1'b0, 2'b10, '0, "R5 oow word");
    access(1'b0, 2'b00, '0, "R5 oow byte");
    access(1'b1, 2'b01, 32'h1234, "R5 oow write");
    load(16'h0100, 20);
    access(1'b0, 2'b01, '0, "R5 oow half after write");

    // R5 word straddling PROM end
    load(30, 20);
    access(1'b1, 2'b10, 32'ha1b2c3d4, "R5 straddle write");
    load(28, 20);
    access(1'b0, 2'b10, '0, "R5 prom tail");
    access(1'b0, 2'b10, '0, "R5 straddle read");

    // R8 exact count exhaustion with 1-byte steps
    load(PMEM_START + 8, 3);
    access(1'b0, 2'b00, '0, "R8 count 3");
    access(1'b0, 2'b00, '0, "R8 count 2");
    access(1'b0, 2'b00, '0, "R8 count 1");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      if (($urandom() % 20) == 0) begin
        int sel, a;
        sel = $urandom() % 4;
        page_stop_i = 8'(6 + ($urandom() % 3));
        a = (sel == 0) ? ($urandom() % 40) :
            (sel == 3) ? ($urandom() & 32'hffff) :
            (PMEM_START + ($urandom() % (MEM_SIZE - PMEM_START)));
        load(a, $urandom() % 48);
      end
      access(1'($urandom()), 2'($urandom()), $urandom(), "R4 R5 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule